// File: doc/BRIEF.md
# Per-Tile CHR Bank Steering for Background Fetches

This block sits beside the picture processor's pattern bus and gives every background tile its own choice of pattern memory. Whenever the picture processor reads a tile index from the console's nametable RAM, the block reads the byte at the same offset from a 2 KiB shadow RAM in the same cycle. The shadow RAM is large enough to hold one byte for every tile of two full nametables. At the next clock edge the block latches that byte.

The latched byte steers the two pattern fetches that follow for that tile. Bit 6 chooses the source: 1 selects CHR-ROM and 0 selects CHR-RAM. For ROM, bits 5..0 drive the upper ROM address lines A11 through A16, which spans 128 KiB. For RAM, bit 0 becomes RAM address bit 12, choosing one of two 4 KiB pages.

Attribute reads and palette reads leave the latch untouched. Pattern fetches that are not tied to a fresh tile are treated as sprite fetches and use a plain default mapping. This covers a third or later pattern read after a tile, and pattern reads that follow a repeated nametable address. CPU access to the shadow RAM and the expansion of pattern data are handled outside this block.

Top module: `tile_bank_steer`

## Requirements
- R1: After reset, and before any nametable fetch, a pattern read (strobe high, A13=0) asserts only the CHR-RAM select, with RAM A12 equal to PPU A12 and the ROM bank output at 0.
- R2: A nametable fetch asserts the shadow chip enable in the same cycle, with shadow address = {CIRAM A10, PPU A9..A0}. A nametable fetch is a read with A13=1, A13..A8 not equal to 0x3F, and A9..A0 below 0x3C0.
- R3: A read with A13=1 and A9..A6 all ones (offset 0x3C0 and above) does not assert the shadow enable and does not reload the latch.
- R4: If the latched byte has bit 6 = 1, the first two pattern reads after its nametable fetch assert only the ROM select, and the ROM bank output equals bits 5..0 of that byte.
- R5: If the latched byte has bit 6 = 0, those two pattern reads assert only the RAM select, with RAM A12 equal to bit 0 of the byte and the ROM bank output at 0.
- R6: The third and later pattern reads after a nametable fetch use the default mapping: RAM select only, with RAM A12 equal to PPU A12.
- R7: A nametable fetch whose shadow address equals that of the previous nametable fetch does not reload the latch. Pattern reads that follow it use the default mapping.
- R8: While the read strobe is low, the shadow enable and both chip selects are deasserted.
- R9: Reads in the palette region (A13..A8 = 0x3F) do not assert the shadow enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one fetch per cycle |
| rst | input | 1 | Synchronous reset, active high |
| ppu_rd | input | 1 | Read strobe of the picture bus, active high |
| ppu_addr | input | 14 | Picture bus address A13..A0 |
| ciram_a10 | input | 1 | Nametable page bit from the mirroring logic |
| qt_rdata | input | 7 | Shadow RAM read data, bits 6..0 |
| qt_ce | output | 1 | Shadow RAM chip enable, active high |
| qt_addr | output | 11 | Shadow RAM address |
| chr_rom_cs | output | 1 | CHR-ROM select, active high |
| chr_ram_cs | output | 1 | CHR-RAM select, active high |
| chr_rom_bank | output | 6 | CHR-ROM address lines A16..A11 |
| chr_ram_a12 | output | 1 | CHR-RAM address bit 12 |

## Verification
The only hidden state is the latched byte, a count of pattern reads since the last tile, and the last nametable address. Each of these shows on the selects at the very next pattern read. A stale or wrongly reloaded latch shows up as a wrong bank or a wrong source on the first pattern read after an attribute or repeated-address fetch. A count that is off by one either holds a tile's mapping into the sprite region or drops it before the tile's second plane. The directed sequences sample the pattern reads just before and just after each of these boundaries.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
    localparam int PPU_AW    = 14;
    localparam int SHADOW_AW = 11;
    localparam int BANK_W    = 6;
    localparam int SRC_BIT   = 6;
    localparam int PAGE_W    = 10;

    typedef enum logic [1:0] {
        FK_IDLE    = 2'd0,
        FK_NAME    = 2'd1,
        FK_OTHER   = 2'd2,
        FK_PATTERN = 2'd3
    } fetch_kind_e;

    typedef struct packed {
        logic              from_rom;
        logic [BANK_W-1:0] bank;
    } tile_sel_t;

    function automatic tile_sel_t unpack_shadow(input logic [SRC_BIT:0] b);
        tile_sel_t s;
        s.from_rom = b[SRC_BIT];
        s.bank     = b[BANK_W-1:0];
        return s;
    endfunction

    function automatic logic in_attr_area(input logic [PAGE_W-1:0] off);
        return off[PAGE_W-1:PAGE_W-4] == 4'hF;
    endfunction
endpackage

// File: rtl/tbs_fetch_decode.sv
module tbs_fetch_decode
    import tbs_pkg::*;
#(
    parameter int AW = PPU_AW
) (
    input  logic          rd,
    input  logic [AW-1:0] addr,
    output fetch_kind_e   kind
);
    localparam int PAL_W = AW - 8;

    always_comb begin
        if (!rd)
            kind = FK_IDLE;
        else if (!addr[AW-1])
            kind = FK_PATTERN;
        else if (addr[AW-1:8] == {PAL_W{1'b1}})
            kind = FK_OTHER;
        else if (in_attr_area(addr[PAGE_W-1:0]))
            kind = FK_OTHER;
        else
            kind = FK_NAME;
    end
endmodule

// File: rtl/tbs_tile_state.sv
module tbs_tile_state
    import tbs_pkg::*;
#(
    parameter int KEY_W        = SHADOW_AW,
    parameter int TILE_FETCHES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  fetch_kind_e      kind,
    input  logic [KEY_W-1:0] key,
    input  logic [SRC_BIT:0] shadow_byte,
    output tile_sel_t        cur,
    output logic             bg_live
);
    localparam int CNT_W = $clog2(TILE_FETCHES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TILE_FETCHES);

    logic [CNT_W-1:0] used_q;
    logic [KEY_W-1:0] last_key_q;
    logic             last_ok_q;
    tile_sel_t        sel_q;
    logic             fresh;

    assign fresh   = (kind == FK_NAME) && !(last_ok_q && last_key_q == key);
    assign bg_live = used_q < CNT_MAX;
    assign cur     = sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            used_q     <= CNT_MAX;
            last_key_q <= '0;
            last_ok_q  <= 1'b0;
            sel_q      <= '0;
        end else begin
            if (kind == FK_NAME) begin
                last_key_q <= key;
                last_ok_q  <= 1'b1;
                if (fresh) begin
                    sel_q  <= unpack_shadow(shadow_byte);
                    used_q <= '0;
                end else begin
                    used_q <= CNT_MAX;
                end
            end else if (kind == FK_PATTERN && bg_live) begin
                used_q <= used_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tbs_select.sv
module tbs_select
    import tbs_pkg::*;
(
    input  fetch_kind_e       kind,
    input  logic              bg_live,
    input  tile_sel_t         cur,
    input  logic              ppu_a12,
    output logic              rom_cs,
    output logic              ram_cs,
    output logic [BANK_W-1:0] rom_bank,
    output logic              ram_a12
);
    logic pat, use_tile;

    assign pat      = (kind == FK_PATTERN);
    assign use_tile = pat && bg_live;

    always_comb begin
        rom_cs   = 1'b0;
        ram_cs   = 1'b0;
        rom_bank = '0;
        ram_a12  = ppu_a12;
        if (use_tile) begin
            if (cur.from_rom) begin
                rom_cs   = 1'b1;
                rom_bank = cur.bank;
            end else begin
                ram_cs  = 1'b1;
                ram_a12 = cur.bank[0];
            end
        end else if (pat) begin
            ram_cs = 1'b1;
        end
    end
endmodule

// File: rtl/tile_bank_steer.sv
module tile_bank_steer
    import tbs_pkg::*;
#(
    parameter int AW           = PPU_AW,
    parameter int SAW          = SHADOW_AW,
    parameter int TILE_FETCHES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ppu_rd,
    input  logic [AW-1:0]     ppu_addr,
    input  logic              ciram_a10,
    input  logic [SRC_BIT:0]  qt_rdata,
    output logic              qt_ce,
    output logic [SAW-1:0]    qt_addr,
    output logic              chr_rom_cs,
    output logic              chr_ram_cs,
    output logic [BANK_W-1:0] chr_rom_bank,
    output logic              chr_ram_a12
);
    fetch_kind_e kind;
    tile_sel_t   cur;
    logic        bg_live;

    tbs_fetch_decode #(.AW(AW)) u_dec (
        .rd   (ppu_rd),
        .addr (ppu_addr),
        .kind (kind)
    );

    assign qt_ce   = (kind == FK_NAME);
    assign qt_addr = {ciram_a10, ppu_addr[SAW-2:0]};

    tbs_tile_state #(.KEY_W(SAW), .TILE_FETCHES(TILE_FETCHES)) u_state (
        .clk         (clk),
        .rst         (rst),
        .kind        (kind),
        .key         (qt_addr),
        .shadow_byte (qt_rdata),
        .cur         (cur),
        .bg_live     (bg_live)
    );

    tbs_select u_sel (
        .kind     (kind),
        .bg_live  (bg_live),
        .cur      (cur),
        .ppu_a12  (ppu_addr[12]),
        .rom_cs   (chr_rom_cs),
        .ram_cs   (chr_ram_cs),
        .rom_bank (chr_rom_bank),
        .ram_a12  (chr_ram_a12)
    );
endmodule

// File: rtl/tbs_checker.sv
module tbs_checker (
    input logic        clk,
    input logic        rst,
    input logic        ppu_rd,
    input logic [13:0] ppu_addr,
    input logic        ciram_a10,
    input logic        qt_ce,
    input logic [10:0] qt_addr,
    input logic        chr_rom_cs,
    input logic        chr_ram_cs,
    input logic [5:0]  chr_rom_bank
);
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !ppu_rd |-> !qt_ce && !chr_rom_cs && !chr_ram_cs);

    a_r2_shadow_addr: assert property (@(posedge clk) disable iff (rst)
        (ppu_rd && ppu_addr[13] && ppu_addr[13:8] != 6'h3F && ppu_addr[9:6] != 4'hF)
        |-> qt_ce && qt_addr == {ciram_a10, ppu_addr[9:0]});

    a_r3_attr_no_ce: assert property (@(posedge clk) disable iff (rst)
        (ppu_addr[13] && ppu_addr[9:6] == 4'hF) |-> !qt_ce);

    a_r9_pal_no_ce: assert property (@(posedge clk) disable iff (rst)
        (ppu_addr[13:8] == 6'h3F) |-> !qt_ce);

    a_r4_one_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0({chr_rom_cs, chr_ram_cs}));

    a_r6_sel_on_pattern: assert property (@(posedge clk) disable iff (rst)
        (chr_rom_cs || chr_ram_cs) |-> ppu_rd && !ppu_addr[13]);

    a_r4_bank_hold: assert property (@(posedge clk) disable iff (rst)
        (chr_rom_cs && $past(chr_rom_cs)) |-> $stable(chr_rom_bank));
endmodule

bind tile_bank_steer tbs_checker u_tbs_checker (
    .clk          (clk),
    .rst          (rst),
    .ppu_rd       (ppu_rd),
    .ppu_addr     (ppu_addr),
    .ciram_a10    (ciram_a10),
    .qt_ce        (qt_ce),
    .qt_addr      (qt_addr),
    .chr_rom_cs   (chr_rom_cs),
    .chr_ram_cs   (chr_ram_cs),
    .chr_rom_bank (chr_rom_bank)
);

// File: tb/tile_bank_steer_bench.sv
module tile_bank_steer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ppu_rd = 1'b0;
    logic [13:0] ppu_addr = '0;
    logic        ciram_a10 = 1'b0;
    logic [6:0]  qt_rdata = '0;
    logic        qt_ce;
    logic [10:0] qt_addr;
    logic        chr_rom_cs, chr_ram_cs, chr_ram_a12;
    logic [5:0]  chr_rom_bank;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    tile_bank_steer u_tile_bank_steer (
        .clk(clk), .rst(rst), .ppu_rd(ppu_rd), .ppu_addr(ppu_addr),
        .ciram_a10(ciram_a10), .qt_rdata(qt_rdata), .qt_ce(qt_ce),
        .qt_addr(qt_addr), .chr_rom_cs(chr_rom_cs), .chr_ram_cs(chr_ram_cs),
        .chr_rom_bank(chr_rom_bank), .chr_ram_a12(chr_ram_a12)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic rd, input logic [13:0] a, input logic a10, input logic [6:0] q);
        @(negedge clk);
        ppu_rd = rd; ppu_addr = a; ciram_a10 = a10; qt_rdata = q;
        #2;
    endtask

    task automatic expect_sel(input string req, input int rom, input int ram, input int bank, input int a12);
        chk(req, "rom_cs", int'(chr_rom_cs), rom);
        chk(req, "ram_cs", int'(chr_ram_cs), ram);
        chk(req, "rom_bank", int'(chr_rom_bank), bank);
        if (ram != 0) chk(req, "ram_a12", int'(chr_ram_a12), a12);
    endtask

    task automatic t_reset();
        drive(1'b0, 14'h0000, 1'b0, 7'h00);
        chk("R8", "qt_ce idle", int'(qt_ce), 0);
        expect_sel("R8", 0, 0, 0, 0);
        drive(1'b1, 14'h1230, 1'b0, 7'h7F);
        expect_sel("R1", 0, 1, 0, 1);
        drive(1'b1, 14'h0230, 1'b0, 7'h7F);
        expect_sel("R1", 0, 1, 0, 0);
    endtask

    task automatic t_rom_tile();
        drive(1'b1, 14'h2045, 1'b1, 7'h6B);
        chk("R2", "qt_ce", int'(qt_ce), 1);
        chk("R2", "qt_addr", int'(qt_addr), 'h445);
        drive(1'b1, 14'h23C1, 1'b1, 7'h55);
        chk("R3", "qt_ce on attr", int'(qt_ce), 0);
        drive(1'b1, 14'h0A50, 1'b0, 7'h00);
        expect_sel("R4", 1, 0, 'h2B, 0);
        drive(1'b1, 14'h0A58, 1'b0, 7'h00);
        expect_sel("R3", 1, 0, 'h2B, 0);
        drive(1'b1, 14'h1A50, 1'b0, 7'h00);
        expect_sel("R6", 0, 1, 0, 1);
        drive(1'b1, 14'h0A50, 1'b0, 7'h00);
        expect_sel("R6", 0, 1, 0, 0);
    endtask

    task automatic t_ram_tile();
        drive(1'b1, 14'h2100, 1'b0, 7'h01);
        chk("R2", "qt_addr page0", int'(qt_addr), 'h100);
        drive(1'b1, 14'h0000, 1'b0, 7'h00);
        expect_sel("R5", 0, 1, 0, 1);
        drive(1'b1, 14'h0008, 1'b0, 7'h00);
        expect_sel("R5", 0, 1, 0, 1);
        drive(1'b1, 14'h0010, 1'b0, 7'h00);
        expect_sel("R6", 0, 1, 0, 0);
    endtask

    task automatic t_repeat();
        drive(1'b1, 14'h2200, 1'b0, 7'h45);
        drive(1'b1, 14'h0010, 1'b0, 7'h00);
        expect_sel("R4", 1, 0, 'h05, 0);
        drive(1'b1, 14'h2200, 1'b0, 7'h7F);
        chk("R7", "qt_ce repeat", int'(qt_ce), 1);
        drive(1'b1, 14'h0010, 1'b0, 7'h00);
        expect_sel("R7", 0, 1, 0, 0);
        drive(1'b1, 14'h2201, 1'b0, 7'h7F);
        drive(1'b1, 14'h0010, 1'b0, 7'h00);
        expect_sel("R7", 1, 0, 'h3F, 0);
    endtask

    task automatic t_palette_idle();
        drive(1'b1, 14'h3F00, 1'b1, 7'h41);
        chk("R9", "qt_ce palette", int'(qt_ce), 0);
        drive(1'b1, 14'h3000, 1'b1, 7'h41);
        chk("R2", "qt_ce mirror", int'(qt_ce), 1);
        chk("R2", "qt_addr mirror", int'(qt_addr), 'h400);
        drive(1'b0, 14'h0000, 1'b0, 7'h00);
        chk("R8", "qt_ce idle", int'(qt_ce), 0);
        expect_sel("R8", 0, 0, 0, 0);
        drive(1'b1, 14'h0000, 1'b0, 7'h00);
        expect_sel("R4", 1, 0, 'h01, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=<5000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_rom_tile();
        t_ram_tile();
        t_repeat();
        t_palette_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule